// File: doc/BRIEF.md
# Decimating Interrupt Status Aggregator

This block collects completion events from a bank of audio DMA channels and merges them into one interrupt line. Each channel owns one sticky status bit. A small per-channel event counter sits in front of that bit, so software can ask to be told about every event, every second event or every fourth event. Once a status bit is set it stays set until software clears it by writing a one to it. While it is set, further events on that channel are thrown away and do not count toward the next assertion.

A single write port reaches three registers, chosen by a two-bit address: the status register (write-one-to-clear), the enable mask, and the packed condition fields. The status bits are always visible on a read port, and the enable mask does not gate them. The interrupt output is high whenever some channel has both its status bit and its enable bit set. The block runs on one clock and has a synchronous active-low reset.

Top module: `irq_decimate_agg`

## Requirements
- R1: After reset every status bit, every enable bit, every condition field and every event counter is zero, so `status_o` = 0 and `irq_o` = 0.
- R2: With condition 0 on a channel, an event on a channel whose status bit is clear sets that bit at the next rising clock edge.
- R3: Condition 1 sets the status bit on the 2nd accepted event and condition 2 on the 4th accepted event. The counter then restarts from zero.
- R4: The reserved condition value 3 acts exactly like condition 0: every accepted event sets the status bit.
- R5: An event that arrives while the channel's status bit is already set is discarded and is not counted. A set bit stays set until it is cleared.
- R6: A write to address 0 clears each status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. A clear in the same cycle as an event on that channel wins.
- R7: `irq_o` is the OR over all channels of (status bit AND enable bit). The enable mask is written at address 1 from data bits [NCH-1:0]. Status bits update and read back whether or not the channel is enabled.
- R8: The condition fields are written at address 2. Channel i takes data bits [2i+1:2i]. A channel whose field changes has its event counter reset to zero, and an event on that channel in the same cycle is discarded. A channel whose field is rewritten with the same value keeps its count.
- R9: A write to address 3 changes no status, enable, condition or counter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NCH | One-cycle completion event per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 status clear, 1 enable, 2 conditions, 3 unused |
| wr_data_i | input | 2*NCH | Write data |
| status_o | output | NCH | Sticky status bits, not masked by enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench first drives single events into a channel at condition 0, which shows whether the status bit is set by the first event. It then drives simultaneous events into channels set to conditions 1, 2 and 3, where the cycle at which each bit rises tells the decimation ratios apart and shows that the reserved value acts as every-event. Events sent to a channel whose bit is already set, followed by a clear, show whether dropped events are wrongly counted. Condition rewrites, with and without a change of value, separate counter reset from counter retention. A long pseudo-random mix of events, clears and enable writes is then compared cycle by cycle against an independent model.

// File: rtl/irqa_pkg.sv
`timescale 1ns/1ps
package irqa_pkg;
  localparam int CND_W = 2;

  typedef enum logic [1:0] {
    WA_STATUS = 2'd0,
    WA_ENABLE = 2'd1,
    WA_COND   = 2'd2,
    WA_SPARE  = 2'd3
  } wr_addr_e;

  // Counter value at which the next accepted event sets the status bit.
  function automatic logic [CND_W-1:0] cnt_limit(input logic [CND_W-1:0] cnd);
    case (cnd)
      2'd1:    cnt_limit = 2'd1;  // every 2nd event
      2'd2:    cnt_limit = 2'd3;  // every 4th event
      default: cnt_limit = 2'd0;  // every event, reserved value included
    endcase
  endfunction
endpackage

// File: rtl/irqa_regs.sv
`timescale 1ns/1ps
module irqa_regs #(
  parameter int NCH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_addr,
  input  logic [irqa_pkg::CND_W*NCH-1:0] wr_data,
  output logic [NCH-1:0]               en_q,
  output logic [irqa_pkg::CND_W*NCH-1:0] cond_q,
  output logic [NCH-1:0]               clr_hit,
  output logic [NCH-1:0]               cond_chg
);
  import irqa_pkg::*;

  logic hit_stat, hit_en, hit_cond;
  assign hit_stat = wr_en && (wr_addr == WA_STATUS);
  assign hit_en   = wr_en && (wr_addr == WA_ENABLE);
  assign hit_cond = wr_en && (wr_addr == WA_COND);

  assign clr_hit = hit_stat ? wr_data[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_chg
    assign cond_chg[i] = hit_cond &&
      (wr_data[CND_W*i +: CND_W] != cond_q[CND_W*i +: CND_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      cond_q <= '0;
    end else begin
      if (hit_en)   en_q   <= wr_data[NCH-1:0];
      if (hit_cond) cond_q <= wr_data;
    end
  end
endmodule

// File: rtl/irqa_decim.sv
`timescale 1ns/1ps
module irqa_decim (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       evt,
  input  logic                       clr,
  input  logic [irqa_pkg::CND_W-1:0] cond,
  input  logic                       cond_chg,
  output logic                       stat,
  output logic [irqa_pkg::CND_W-1:0] cnt,
  output logic                       take,
  output logic                       fire
);
  import irqa_pkg::*;

  logic                 stat_q;
  logic [CND_W-1:0]     cnt_q;

  // An event counts only when the bit is clear and no condition change lands.
  assign take = evt && !stat_q && !cond_chg;
  assign fire = take && (cnt_q == cnt_limit(cond));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (clr)       stat_q <= 1'b0;
      else if (fire) stat_q <= 1'b1;

      if (cond_chg)  cnt_q <= '0;
      else if (fire) cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stat = stat_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/irqa_combine.sv
`timescale 1ns/1ps
module irqa_combine #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] stat,
  input  logic [NCH-1:0] en,
  output logic           irq
);
  assign irq = |(stat & en);
endmodule

// File: rtl/irq_decimate_agg.sv
`timescale 1ns/1ps
module irq_decimate_agg #(
  parameter int NCH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NCH-1:0]                 evt_i,
  input  logic                           wr_en_i,
  input  logic [1:0]                     wr_addr_i,
  input  logic [irqa_pkg::CND_W*NCH-1:0] wr_data_i,
  output logic [NCH-1:0]                 status_o,
  output logic                           irq_o
);
  import irqa_pkg::*;

  logic [NCH-1:0]       en_w, clr_w, chg_w, take_w, fire_w, stat_w;
  logic [CND_W*NCH-1:0] cond_w, cnt_w;

  irqa_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .en_q(en_w), .cond_q(cond_w),
    .clr_hit(clr_w), .cond_chg(chg_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    irqa_decim u_decim (
      .clk(clk), .rst_n(rst_n), .evt(evt_i[i]), .clr(clr_w[i]),
      .cond(cond_w[CND_W*i +: CND_W]), .cond_chg(chg_w[i]),
      .stat(stat_w[i]), .cnt(cnt_w[CND_W*i +: CND_W]),
      .take(take_w[i]), .fire(fire_w[i])
    );
  end

  irqa_combine #(.NCH(NCH)) u_comb (.stat(stat_w), .en(en_w), .irq(irq_o));

  assign status_o = stat_w;
endmodule

// File: rtl/irqa_chk.sv
`timescale 1ns/1ps
module irqa_chk #(
  parameter int NCH = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NCH-1:0]                 evt_i,
  input logic [NCH-1:0]                 status_o,
  input logic                           irq_o,
  input logic [NCH-1:0]                 take,
  input logic [NCH-1:0]                 fire,
  input logic [NCH-1:0]                 clr_hit,
  input logic [NCH-1:0]                 cond_chg,
  input logic [irqa_pkg::CND_W*NCH-1:0] cond,
  input logic [irqa_pkg::CND_W*NCH-1:0] cnt
);
  import irqa_pkg::*;

  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != '0));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_rise_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[i]) |-> $past(fire[i]));
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[i] |=> !status_o[i]);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[i] && !clr_hit[i]) |=> status_o[i]);
    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && status_o[i]) |-> !take[i]);
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[CND_W*i +: CND_W] <= cnt_limit(cond[CND_W*i +: CND_W]));
    p_chg_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cond_chg[i] |=> (cnt[CND_W*i +: CND_W] == '0));
  end
endmodule

bind irq_decimate_agg irqa_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .status_o(status_o),
  .irq_o(irq_o), .take(take_w), .fire(fire_w), .clr_hit(clr_w),
  .cond_chg(chg_w), .cond(cond_w), .cnt(cnt_w)
);

// File: tb/tb_irq_decimate_agg.sv
`timescale 1ns/1ps
module tb_irq_decimate_agg;
  localparam int NCH = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  evt_i = '0;
  logic            wr_en_i = 1'b0;
  logic [1:0]      wr_addr_i = 2'd0;
  logic [2*NCH-1:0] wr_data_i = '0;
  logic [NCH-1:0]  status_o;
  logic            irq_o;

  irq_decimate_agg #(.NCH(NCH)) dut (.*);

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // reference state
  logic [NCH-1:0]   m_st = '0;
  logic [NCH-1:0]   m_en = '0;
  logic [2*NCH-1:0] m_cond = '0;
  int               m_cnt [NCH];

  // scoreboard queues
  logic [NCH-1:0] q_st [$];
  logic           q_irq [$];
  string          q_tag [$];

  function automatic int events_needed(input logic [1:0] c);
    if (c == 2'd1) return 2;
    if (c == 2'd2) return 4;
    return 1;
  endfunction

  task automatic drive(input logic [NCH-1:0] ev, input logic we,
                       input logic [1:0] wa, input logic [2*NCH-1:0] wd,
                       input string tag);
    logic [NCH-1:0] nxt;
    @(negedge clk);
    evt_i = ev; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    for (int ch = 0; ch < NCH; ch++) begin
      logic chg, clr, hit;
      chg = we && (wa == 2'd2) && (wd[2*ch +: 2] != m_cond[2*ch +: 2]);
      clr = we && (wa == 2'd0) && wd[ch];
      hit = 1'b0;
      if (chg) m_cnt[ch] = 0;
      else if (ev[ch] && !m_st[ch]) begin
        m_cnt[ch]++;
        if (m_cnt[ch] >= events_needed(m_cond[2*ch +: 2])) begin
          hit = 1'b1;
          m_cnt[ch] = 0;
        end
      end
      nxt[ch] = clr ? 1'b0 : (m_st[ch] | hit);
    end
    if (we && wa == 2'd1) m_en = wd[NCH-1:0];
    if (we && wa == 2'd2) m_cond = wd;
    m_st = nxt;
    q_st.push_back(m_st);
    q_irq.push_back(|(m_st & m_en));
    q_tag.push_back(tag);
  endtask

  task automatic ev(input logic [NCH-1:0] m, input string tag);
    drive(m, 1'b0, 2'd0, '0, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [2*NCH-1:0] d, input string tag);
    drive('0, 1'b1, a, d, tag);
  endtask

  // monitor: pops one expectation per edge, samples 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_st.size() > 0) begin
        logic [NCH-1:0] es;
        logic ei;
        string t;
        es = q_st.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
        total++;
        if (status_o !== es || irq_o !== ei) begin
          bad++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   t, status_o, irq_o, es, ei);
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ev('0, "R1 reset state");
    wr(2'd1, 16'h00FF, "R7 enable all, no status");

    // R2: every event at condition 0
    ev(8'h01, "R2 first event sets bit");
    ev(8'h01, "R5 event on set bit dropped");
    wr(2'd0, 16'h0000, "R6 zero write no effect");
    wr(2'd0, 16'h0001, "R6 clear set bit");
    ev(8'h01, "R2 sets again after clear");
    wr(2'd0, 16'h00FF, "R6 clear all");

    // R3/R4: ch1 cond1, ch2 cond2, ch3 cond3 (reserved)
    wr(2'd2, 16'h00E4, "R8 write conditions");
    for (int k = 0; k < 4; k++) ev(8'h0E, "R3 R4 decimated events");
    wr(2'd0, 16'h00FF, "R6 clear all");

    // R5: dropped events not counted (ch1 every 2nd)
    ev(8'h02, "R3 ch1 first of two");
    ev(8'h02, "R3 ch1 second sets");
    for (int k = 0; k < 3; k++) ev(8'h02, "R5 drops while set");
    wr(2'd0, 16'h0002, "R6 clear ch1");
    ev(8'h02, "R5 one fresh event not enough");
    ev(8'h02, "R5 second fresh event sets");
    wr(2'd0, 16'h00FF, "R6 clear all");

    // R7: status independent of enable
    wr(2'd1, 16'h0000, "R7 mask all");
    ev(8'h10, "R7 status set while masked");
    wr(2'd1, 16'h0010, "R7 enable raises irq");
    wr(2'd1, 16'h0020, "R7 other enable drops irq");
    wr(2'd0, 16'h0010, "R6 clear ch4");
    wr(2'd1, 16'h00FF, "R7 enable all");

    // R8: same value keeps count, change resets it
    ev(8'h02, "R8 ch1 count one");
    wr(2'd2, 16'h00E4, "R8 rewrite same value");
    ev(8'h02, "R8 kept count sets");
    wr(2'd0, 16'h0002, "R6 clear ch1");
    ev(8'h02, "R8 ch1 count one again");
    wr(2'd2, 16'h00E8, "R8 ch1 changed to every 4th");
    for (int k = 0; k < 4; k++) ev(8'h02, "R8 four events after reset");
    wr(2'd0, 16'h00FF, "R6 clear all");
    drive(8'h02, 1'b1, 2'd2, 16'h00E4, "R8 event with change discarded");
    ev(8'h02, "R8 count from zero");
    ev(8'h02, "R8 sets at second");

    // R9: unused address
    wr(2'd3, 16'hFFFF, "R9 spare write ignored");
    ev(8'h08, "R9 condition unchanged");
    wr(2'd3, 16'h0000, "R9 spare write keeps enable");
    wr(2'd0, 16'h00FF, "R6 clear all");

    // mixed traffic against the model
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)      drive(r[15:8], 1'b1, 2'd0, {8'h00, r[23:16]}, "R6 random clear");
      else if (r[3:0] == 4'd1) drive(r[15:8], 1'b1, 2'd1, {8'h00, r[23:16]}, "R7 random enable");
      else if (r[3:0] == 4'd2) drive(r[15:8], 1'b1, 2'd2, r[31:16], "R8 random conditions");
      else                     ev(r[15:8], "R3 random events");
    end

    repeat (3) @(negedge clk);
    if (q_st.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: pending=%0d expected 0", q_st.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule